// File: doc/BRIEF.md
# Interrupt Vector Priority Resolver

This block works out the words that software receives when it reads the two vector registers of a 64-source interrupt controller. One register serves the ordinary interrupts and the other the fast ones. Four vectors come in: pending, enable, fast type, and a 4-bit priority for each source. There is also one read strobe for each register. The block returns a 32-bit read word for each register. It also gives a one-hot clear request that removes the pending bit of the source the read has handed out.

Both choices are made by combinational reduction trees over all sources.

- **Ordinary path:** the highest priority value wins. When priorities are equal, the higher source number wins.
- **Fast path:** the lowest source number wins.

When a register is read, its result word is loaded into an output register and held there until that register is read again. The clear request is driven during the strobe cycle only. Address decoding and the logic that applies the clear sit outside this block.

Top module: `vec_resolver`

## Requirements
- R1: A source is a candidate for the ordinary register when it is pending, enabled, and its fast-type bit is 0. No other source affects that register.
- R2: Among ordinary candidates, the one with the greatest priority value is chosen. Among equal priorities, the higher source number is chosen. The priority of source k is `prio_i[4k+3:4k]`.
- R3: The ordinary result word holds the chosen source number, zero-extended, in bits 31:16 and its priority in bits 3:0. Bits 15:4 are zero.
- R4: A source is a fast candidate when it is pending, enabled, and its fast-type bit is 1. The lowest-numbered one is chosen. The fast result word is its number, zero-extended to 32 bits.
- R5: A read of either register that finds no candidate returns 0xFFFFFFFF.
- R6: During a strobe cycle that has a candidate, the clear output of that register has exactly the chosen source's bit set. It is all zero in every other cycle, including a strobe cycle with no candidate.
- R7: A read word appears on the register's output in the cycle after the strobe and holds until that register's next strobe. Both outputs reset to 0.
- R8: A priority of 0 does not stop a source from being chosen.
- R9: The two registers can be read in the same cycle, and each read gives the same result it would give alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | 64 | Pending bit per source |
| en_i | input | 64 | Enable bit per source |
| fast_i | input | 64 | Fast-type bit per source |
| prio_i | input | 256 | 4-bit priority per source, source k at bits 4k+3:4k |
| rd_norm_i | input | 1 | Read strobe of the ordinary vector register |
| rd_fast_i | input | 1 | Read strobe of the fast vector register |
| norm_rdata_o | output | 32 | Ordinary vector result word |
| fast_rdata_o | output | 32 | Fast vector result word |
| norm_clr_o | output | 64 | One-hot clear request from an ordinary read |
| fast_clr_o | output | 64 | One-hot clear request from a fast read |

## Verification
The bench targets the following corner cases:

- **Ties in priority.** A tree that prefers the left branch would return the lowest source number instead of the highest.
- **Sources excluded by enable or type.** A gating error would let a disabled or wrong-type source win.
- **Source 0 with priority 0.** A design that uses priority zero to mean "nothing pending" would read 0xFFFFFFFF here.
- **Empty reads.** These must raise no clear bit and must load the all-ones word.
- **Reads of both registers in the same cycle.**
- **Cycles without a strobe.** A read word that is not held, or a clear asserted outside the strobe, is caught here.

// File: rtl/vec_resolver_pkg.sv
package vec_resolver_pkg;

    localparam int NUM_SRC  = 64;
    localparam int PRIO_W   = 4;
    localparam int SRC_W    = $clog2(NUM_SRC);
    localparam int WORD_W   = 32;
    localparam int NUM_FLD  = 16;
    localparam logic [WORD_W-1:0] EMPTY_WORD = '1;

    typedef enum logic { SEL_PRIO_HIGH, SEL_INDEX_LOW } sel_mode_e;

    typedef struct packed {
        logic              valid;
        logic [SRC_W-1:0]  idx;
        logic [PRIO_W-1:0] prio;
    } cand_t;

    // Merge two subtrees; lo covers lower source numbers than hi.
    function automatic cand_t pick(input cand_t lo, input cand_t hi, input sel_mode_e mode);
        cand_t r;
        if (mode == SEL_INDEX_LOW) begin
            r = lo.valid ? lo : hi;
        end else begin
            if (hi.valid && (!lo.valid || hi.prio >= lo.prio))
                r = hi;
            else
                r = lo;
        end
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] norm_word(input cand_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[WORD_W-1 -: NUM_FLD] = {{(NUM_FLD-SRC_W){1'b0}}, c.idx};
        w[PRIO_W-1:0]          = c.prio;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] fast_word(input cand_t c);
        return {{(WORD_W-SRC_W){1'b0}}, c.idx};
    endfunction

endpackage

// File: rtl/vr_select_tree.sv
module vr_select_tree
    import vec_resolver_pkg::*;
#(
    parameter int        N      = NUM_SRC,
    parameter sel_mode_e MODE   = SEL_PRIO_HIGH,
    parameter int        IDX_W  = SRC_W,
    parameter int        PW     = PRIO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      cand_i,
    input  logic [N*PW-1:0]   prio_i,
    output cand_t             win_o
);
    localparam int LVLS  = $clog2(N);
    localparam int P2    = 1 << LVLS;
    localparam int NODES = 2*P2 - 1;

    cand_t node [NODES];

    genvar g;
    generate
        for (g = 0; g < P2; g++) begin : g_leaf
            if (g < N) begin : g_real
                assign node[P2-1+g] = '{valid: cand_i[g],
                                        idx:   IDX_W'(g),
                                        prio:  prio_i[g*PW +: PW]};
            end else begin : g_pad
                assign node[P2-1+g] = '0;
            end
        end
        for (g = 0; g < P2-1; g++) begin : g_inner
            assign node[g] = pick(node[2*g+1], node[2*g+2], MODE);
        end
    endgenerate

    assign win_o = node[0];

    // R2 R4: no candidate may beat the root under the mode's ordering
    always @(posedge clk) begin
        if (!rst) begin
            for (int i = 0; i < N; i++) begin
                if (cand_i[i]) begin
                    // R2
                    if (MODE == SEL_PRIO_HIGH) begin
                        tree_best_chk: assert (win_o.valid &&
                            (prio_i[i*PW +: PW] < win_o.prio ||
                             (prio_i[i*PW +: PW] == win_o.prio && i <= int'(win_o.idx))));
                    end else begin
                        // R4
                        tree_lowest_chk: assert (win_o.valid && i >= int'(win_o.idx));
                    end
                end
            end
            // R1
            tree_valid_chk: assert (win_o.valid == (|cand_i));
        end
    end

endmodule

// File: rtl/vr_read_port.sv
module vr_read_port
    import vec_resolver_pkg::*;
#(
    parameter int        N    = NUM_SRC,
    parameter sel_mode_e MODE = SEL_PRIO_HIGH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_i,
    input  logic [N-1:0]      cand_i,
    input  cand_t             win_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic [N-1:0]      clr_o
);
    logic [WORD_W-1:0] word_d;

    always_comb begin
        if (!win_i.valid)
            word_d = EMPTY_WORD;
        else if (MODE == SEL_PRIO_HIGH)
            word_d = norm_word(win_i);
        else
            word_d = fast_word(win_i);
    end

    always_comb begin
        clr_o = '0;
        if (rd_i && win_i.valid)
            clr_o[win_i.idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_o <= '0;
        else if (rd_i)
            rdata_o <= word_d;
    end

    // R6
    clr_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(clr_o));
    // R6
    clr_strobe_chk: assert property (@(posedge clk) disable iff (rst) !rd_i |-> clr_o == '0);
    // R6
    clr_cand_chk: assert property (@(posedge clk) disable iff (rst) (clr_o & ~cand_i) == '0);
    // R5
    empty_word_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_i && cand_i == '0) |=> rdata_o == EMPTY_WORD);
    // R7
    hold_word_chk: assert property (@(posedge clk) disable iff (rst) !rd_i |=> $stable(rdata_o));

endmodule

// File: rtl/vec_resolver.sv
module vec_resolver
    import vec_resolver_pkg::*;
#(
    parameter int N  = NUM_SRC,
    parameter int PW = PRIO_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      pend_i,
    input  logic [N-1:0]      en_i,
    input  logic [N-1:0]      fast_i,
    input  logic [N*PW-1:0]   prio_i,
    input  logic              rd_norm_i,
    input  logic              rd_fast_i,
    output logic [WORD_W-1:0] norm_rdata_o,
    output logic [WORD_W-1:0] fast_rdata_o,
    output logic [N-1:0]      norm_clr_o,
    output logic [N-1:0]      fast_clr_o
);
    logic [N-1:0] live;
    logic [N-1:0] norm_cand;
    logic [N-1:0] fast_cand;
    cand_t        norm_win;
    cand_t        fast_win;

    assign live      = pend_i & en_i;
    assign norm_cand = live & ~fast_i;
    assign fast_cand = live &  fast_i;

    vr_select_tree #(.N(N), .MODE(SEL_PRIO_HIGH), .IDX_W(SRC_W), .PW(PW)) u_norm_tree (
        .clk(clk), .rst(rst), .cand_i(norm_cand), .prio_i(prio_i), .win_o(norm_win));

    vr_select_tree #(.N(N), .MODE(SEL_INDEX_LOW), .IDX_W(SRC_W), .PW(PW)) u_fast_tree (
        .clk(clk), .rst(rst), .cand_i(fast_cand), .prio_i(prio_i), .win_o(fast_win));

    vr_read_port #(.N(N), .MODE(SEL_PRIO_HIGH)) u_norm_port (
        .clk(clk), .rst(rst), .rd_i(rd_norm_i), .cand_i(norm_cand), .win_i(norm_win),
        .rdata_o(norm_rdata_o), .clr_o(norm_clr_o));

    vr_read_port #(.N(N), .MODE(SEL_INDEX_LOW)) u_fast_port (
        .clk(clk), .rst(rst), .rd_i(rd_fast_i), .cand_i(fast_cand), .win_i(fast_win),
        .rdata_o(fast_rdata_o), .clr_o(fast_clr_o));

    // R1 R4: a source cleared by one path never belongs to the other
    // R9
    path_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        (norm_clr_o & fast_clr_o) == '0);
    // R1
    norm_type_chk: assert property (@(posedge clk) disable iff (rst)
        (norm_clr_o & (fast_i | ~pend_i | ~en_i)) == '0);

endmodule

// File: tb/vec_resolver_bench.sv
`timescale 1ns/1ps
module vec_resolver_bench;
    localparam int N = 64;
    localparam int PW = 4;

    typedef struct packed {
        logic [63:0] pend;
        logic [63:0] en;
        logic [63:0] fast;
        logic [7:0]  pmul;
        logic [7:0]  padd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                  8'd7, 8'd3},
        '{64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 8'd0, 8'd5},
        '{64'h0F0F_0000_1234_5678, 64'h00FF_FFFF_FFFF_0000, 64'h0000_1111_0000_0000, 8'd5, 8'd1},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_00F0, 64'h0000_0000_0000_0030, 8'd3, 8'd0},
        '{64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF0F0_F0F0_F0F0_F0F0, 8'd11, 8'd9},
        '{64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_0000_0000_0000, 8'd1, 8'd1},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 8'd13, 8'd2},
        '{64'h1000_0000_0000_0100, 64'h1000_0000_0000_0100, 64'h0,                  8'd0, 8'd0}
    };

    logic          clk = 0;
    logic          rst = 1;
    logic [63:0]   pend = '0, en = '0, fast = '0;
    logic [255:0]  prio = '0;
    logic          rd_n = 0, rd_f = 0;
    logic [31:0]   n_rd, f_rd;
    logic [63:0]   n_clr, f_clr;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    vec_resolver u_vec_resolver (
        .clk(clk), .rst(rst), .pend_i(pend), .en_i(en), .fast_i(fast), .prio_i(prio),
        .rd_norm_i(rd_n), .rd_fast_i(rd_f),
        .norm_rdata_o(n_rd), .fast_rdata_o(f_rd), .norm_clr_o(n_clr), .fast_clr_o(f_clr));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] mk_prio(input int mul, input int add);
        logic [255:0] p;
        for (int k = 0; k < N; k++) p[k*PW +: PW] = 4'((k*mul + add) & 15);
        return p;
    endfunction

    // Reference: scan from source 0 upward, keep a source if strictly better or equal-priority
    function automatic int ref_norm(output logic [31:0] word);
        int best = -1;
        int bp = -1;
        for (int k = 0; k < N; k++) begin
            if (pend[k] && en[k] && !fast[k] && int'(prio[k*PW +: PW]) >= bp) begin
                best = k; bp = int'(prio[k*PW +: PW]);
            end
        end
        word = (best < 0) ? 32'hFFFF_FFFF : ((32'(best) << 16) | 32'(bp));
        return best;
    endfunction

    function automatic int ref_fast(output logic [31:0] word);
        int best = -1;
        for (int k = N-1; k >= 0; k--)
            if (pend[k] && en[k] && fast[k]) best = k;
        word = (best < 0) ? 32'hFFFF_FFFF : 32'(best);
        return best;
    endfunction

    function automatic logic [63:0] oh(input int k);
        return (k < 0) ? 64'h0 : (64'h1 << k);
    endfunction

    // Strobe both registers, check clears in the strobe cycle and words one cycle later
    task automatic read_both(input bit dn, input bit df, input string tag);
        logic [31:0] wn, wf;
        logic [31:0] old_n, old_f;
        int bn, bf;
        bn = ref_norm(wn);
        bf = ref_fast(wf);
        old_n = n_rd; old_f = f_rd;
        @(negedge clk);
        rd_n = dn; rd_f = df;
        #1;
        check({tag, " R6 norm clear"}, n_clr, dn ? oh(bn) : 64'h0);
        check({tag, " R6 fast clear"}, f_clr, df ? oh(bf) : 64'h0);
        @(negedge clk);
        rd_n = 0; rd_f = 0;
        #1;
        check({tag, " R2 R3 norm word"}, 64'(n_rd), 64'(dn ? wn : old_n));
        check({tag, " R4 fast word"},    64'(f_rd), 64'(df ? wf : old_f));
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R7 reset values
        check("R7 reset norm word", 64'(n_rd), 64'h0);
        check("R7 reset fast word", 64'(f_rd), 64'h0);
        check("R6 idle norm clear", n_clr, 64'h0);

        // Table walk: R1 R2 R3 R4 R5 R9 with both strobes together
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            pend = VECS[v].pend; en = VECS[v].en; fast = VECS[v].fast;
            prio = mk_prio(int'(VECS[v].pmul), int'(VECS[v].padd));
            read_both(1, 1, $sformatf("R9 vec%0d", v));
        end

        // R2 tie: all equal priority, highest number wins
        @(negedge clk);
        pend = '1; en = '1; fast = '0; prio = '0;
        read_both(1, 0, "R2 tie");
        check("R2 tie winner", 64'(n_rd), 64'h003F_0000);

        // R8 priority 0 on a lone source 0
        @(negedge clk);
        pend = 64'h1; en = 64'h1; fast = '0; prio = '0;
        read_both(1, 0, "R8 prio0");
        check("R8 source0 prio0 word", 64'(n_rd), 64'h0);

        // R1 disabled high-priority source ignored
        @(negedge clk);
        pend = 64'h3; en = 64'h1; fast = '0; prio = '0; prio[7:4] = 4'hF;
        read_both(1, 0, "R1 disabled");
        check("R1 disabled source skipped", 64'(n_rd), 64'h0);

        // R4 fast source 0 vs others
        @(negedge clk);
        pend = '1; en = '1; fast = 64'h8000_0000_0000_0001; prio = '1;
        read_both(0, 1, "R4 fast0");
        check("R4 fast lowest", 64'(f_rd), 64'h0);

        // R5 empty on both
        @(negedge clk);
        pend = '0;
        read_both(1, 1, "R5 empty");
        check("R5 norm empty", 64'(n_rd), 64'hFFFF_FFFF);
        check("R5 fast empty", 64'(f_rd), 64'hFFFF_FFFF);

        // R7 hold: change inputs, no strobe, word stays; R6 no clear
        @(negedge clk);
        pend = '1; en = '1; fast = 64'hF0;
        repeat (3) @(negedge clk);
        #1;
        check("R7 norm hold", 64'(n_rd), 64'hFFFF_FFFF);
        check("R7 fast hold", 64'(f_rd), 64'hFFFF_FFFF);
        check("R6 no strobe norm clear", n_clr, 64'h0);
        check("R6 no strobe fast clear", f_clr, 64'h0);

        // R9 only fast read leaves normal word untouched
        read_both(0, 1, "R9 fast only");
        check("R9 fast only word", 64'(f_rd), 64'h4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule